// File: doc/BRIEF.md
# Parallel I/O Port with Edge Capture and Interrupt

This block is a general-purpose parallel I/O port of up to 32 pins that sits on a simple word-indexed register bus. Software holds four per-pin registers: the value to drive, the pin direction, an interrupt enable mask, and a sticky event register. The block drives the pin values and their output enables toward the pad ring. It samples the incoming pin levels through a synchronizer and raises one interrupt line toward the processor.

The interrupt trigger is fixed when the block is built. It may be rising edge, falling edge, either edge, or level high. In the three edge modes, each detected edge latches into the sticky event register, and software clears it by writing ones. In level-high mode there is no latching: the interrupt follows the pin data seen at readback, gated by the mask. A new edge that lands in the same cycle as a software clear of the same bit is kept.

Top module: `pio_edge_top`

## Requirements
- R1: A write happens when `busSel` and `busWr` are both high. A read returns data on `busRdata` in the same cycle when `busSel` is high and `busWr` is low. `busWordAddr` selects the register: 0 is data (byte offset 0x0), 1 is direction (0x4), 2 is interrupt mask (0x8), 3 is event capture (0xC).
- R2: `pinOut` equals the data register and `pinOe` equals the direction register. A direction bit of 1 makes that pin an output. Both outputs change on the clock edge that completes the write.
- R3: A read of the data register returns the data-register bit for output pins and the synchronized pin level for input pins. The synchronized level reflects a pin change two clock edges after the change.
- R4: After reset, every register reads 0, `pinOut` and `pinOe` are 0, and `irq` is 0.
- R5: Bits at or above PIN_COUNT are dropped on write and read as 0.
- R6: In edge modes, a qualifying change of a synchronized pin sets that pin's capture bit on the third clock edge after the pin changes. Rising mode qualifies 0 to 1, falling mode qualifies 1 to 0, and both-edge mode qualifies either change. In level-high mode the capture register always reads 0.
- R7: Writing 1 to a capture bit clears it, and writing 0 leaves it unchanged. If an edge sets a bit in the same cycle a write clears it, the bit ends up set.
- R8: In edge modes, `irq` is the registered OR of (capture AND mask), one cycle behind the registers.
- R9: In level-high mode, `irq` is the registered OR of (data readback AND mask), one cycle behind.
- R10: A pin whose mask bit is 0 never raises `irq`. With the whole mask at 0, `irq` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 for write, 0 for read |
| busWordAddr | input | 2 | Register word index |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| pinIn | input | PIN_COUNT | Pin levels from the pads |
| pinOut | output | PIN_COUNT | Values to drive onto the pins |
| pinOe | output | PIN_COUNT | Per-pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds four copies of the block with PIN_COUNT of 12, one copy for each trigger type. All four share the same bus and the same pins. Because the pin count is below the bus width, the bench can check that upper bits are dropped on write and read as zero. Running the four trigger types side by side on identical stimulus lets the bench compare the rising, falling and both-edge captures against one another, and against level mode, on every edge. This also covers a pin edge that coincides with a clear of its capture bit.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int BUS_W = 32;

  typedef enum logic [1:0] {
    TRIG_RISE  = 2'd0,
    TRIG_FALL  = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_LEVEL = 2'd3
  } trig_e;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_CAP  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrMask;
    logic    clrCap;
    logic    rdEn;
    regSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic       busSel,
  input  logic       busWr,
  input  logic [1:0] busWordAddr,
  output strobe_t    strb
);

  regSel_e sel;
  logic    wrAcc;

  assign sel   = regSel_e'(busWordAddr);
  assign wrAcc = busSel & busWr;

  always_comb begin
    strb        = '0;
    strb.wrData = wrAcc && (sel == SEL_DATA);
    strb.wrDir  = wrAcc && (sel == SEL_DIR);
    strb.wrMask = wrAcc && (sel == SEL_MASK);
    strb.clrCap = wrAcc && (sel == SEL_CAP);
    strb.rdEn   = busSel && !busWr;
    strb.rdSel  = sel;
  end

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int    PIN_COUNT   = 32,
  parameter trig_e TRIG        = TRIG_BOTH,
  parameter int    SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [BUS_W-1:0]     wdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [BUS_W-1:0]     rdata,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic [PIN_COUNT-1:0] capVec,
  output logic [PIN_COUNT-1:0] maskVec,
  output logic                 irq
);

  logic [PIN_COUNT-1:0] outReg, dirReg, maskReg, capReg;
  logic [PIN_COUNT-1:0] pinLvl, dataView, irqSrc, wBits;

  assign wBits = wdata[PIN_COUNT-1:0];

  pio_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (pinIn),
    .dout (pinLvl)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg  <= '0;
      dirReg  <= '0;
      maskReg <= '0;
    end else begin
      if (strb.wrData) outReg  <= wBits;
      if (strb.wrDir)  dirReg  <= wBits;
      if (strb.wrMask) maskReg <= wBits;
    end
  end

  assign dataView = (outReg & dirReg) | (pinLvl & ~dirReg);

  generate
    if (TRIG == TRIG_LEVEL) begin : gLevel
      assign capReg = '0;
      assign irqSrc = dataView;
    end else begin : gEdge
      logic [PIN_COUNT-1:0] prevLvl, edgeEv, clrBits;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevLvl <= '0;
        else       prevLvl <= pinLvl;
      end

      if (TRIG == TRIG_RISE) begin : gRise
        assign edgeEv = pinLvl & ~prevLvl;
      end else if (TRIG == TRIG_FALL) begin : gFall
        assign edgeEv = ~pinLvl & prevLvl;
      end else begin : gAny
        assign edgeEv = pinLvl ^ prevLvl;
      end

      assign clrBits = strb.clrCap ? wBits : '0;

      // a fresh edge overrides a simultaneous clear of the same bit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) capReg <= '0;
        else       capReg <= (capReg & ~clrBits) | edgeEv;
      end

      assign irqSrc = capReg;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= |(irqSrc & maskReg);
  end

  always_comb begin
    rdata = '0;
    if (strb.rdEn) begin
      unique case (strb.rdSel)
        SEL_DATA: rdata = BUS_W'(dataView);
        SEL_DIR:  rdata = BUS_W'(dirReg);
        SEL_MASK: rdata = BUS_W'(maskReg);
        SEL_CAP:  rdata = BUS_W'(capReg);
        default:  rdata = '0;
      endcase
    end
  end

  assign pinOut  = outReg;
  assign pinOe   = dirReg;
  assign capVec  = capReg;
  assign maskVec = maskReg;

endmodule

// File: rtl/pio_edge_top.sv
module pio_edge_top
  import pio_pkg::*;
#(
  parameter int    PIN_COUNT = 32,
  parameter trig_e TRIG      = TRIG_BOTH
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [1:0]           busWordAddr,
  input  logic [BUS_W-1:0]     busWdata,
  output logic [BUS_W-1:0]     busRdata,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic [PIN_COUNT-1:0] pinOut,
  output logic [PIN_COUNT-1:0] pinOe,
  output logic                 irq
);

  strobe_t              strb;
  logic [PIN_COUNT-1:0] capVec, maskVec;

  pio_ctrl uCtrl (
    .busSel      (busSel),
    .busWr       (busWr),
    .busWordAddr (busWordAddr),
    .strb        (strb)
  );

  pio_datapath #(.PIN_COUNT(PIN_COUNT), .TRIG(TRIG)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wdata   (busWdata),
    .pinIn   (pinIn),
    .rdata   (busRdata),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .capVec  (capVec),
    .maskVec (maskVec),
    .irq     (irq)
  );

endmodule

// File: rtl/pio_edge_chk.sv
module pio_edge_chk
  import pio_pkg::*;
#(
  parameter int    PIN_COUNT = 32,
  parameter trig_e TRIG      = TRIG_BOTH
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWr,
  input logic [1:0]           busWordAddr,
  input logic [BUS_W-1:0]     busWdata,
  input logic [PIN_COUNT-1:0] pinOut,
  input logic [PIN_COUNT-1:0] pinOe,
  input logic [PIN_COUNT-1:0] capVec,
  input logic [PIN_COUNT-1:0] maskVec,
  input logic                 irq
);

  logic wrDirAcc, wrDataAcc, zeroCapWr;
  assign wrDirAcc  = busSel && busWr && (busWordAddr == 2'd1);
  assign wrDataAcc = busSel && busWr && (busWordAddr == 2'd0);
  assign zeroCapWr = busSel && busWr && (busWordAddr == 2'd3) && (busWdata == '0);

  a_r2_oe_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    wrDirAcc |=> (pinOe == $past(busWdata[PIN_COUNT-1:0])));

  a_r2_out_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    wrDataAcc |=> (pinOut == $past(busWdata[PIN_COUNT-1:0])));

  a_r7_zero_write_keeps: assert property (@(posedge clk) disable iff (!rstN)
    zeroCapWr |=> ((capVec & $past(capVec)) == $past(capVec)));

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '0) |=> !irq);

  generate
    if (TRIG != TRIG_LEVEL) begin : gEdgeChk
      a_r8_irq_needs_capture: assert property (@(posedge clk) disable iff (!rstN)
        irq |-> $past(|(capVec & maskVec)));
    end
  endgenerate

endmodule

bind pio_edge_top pio_edge_chk #(.PIN_COUNT(PIN_COUNT), .TRIG(TRIG)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWr       (busWr),
  .busWordAddr (busWordAddr),
  .busWdata    (busWdata),
  .pinOut      (pinOut),
  .pinOe       (pinOe),
  .capVec      (capVec),
  .maskVec     (maskVec),
  .irq         (irq)
);

// File: tb/tb_pio_edge_top.sv
`timescale 1ns/1ps
module tb_pio_edge_top;
  import pio_pkg::*;

  localparam int NP = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0, busWr = 1'b0;
  logic [1:0]    busWordAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [NP-1:0] pinIn = '0;

  logic [31:0]   rd [4];
  logic [NP-1:0] po [4];
  logic [NP-1:0] poe [4];
  logic [3:0]    irqs;

  int nChecks = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  // index 0 rise, 1 fall, 2 both (dut), 3 level
  pio_edge_top #(.PIN_COUNT(NP), .TRIG(TRIG_RISE)) dutRise (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busWordAddr(busWordAddr),
    .busWdata(busWdata), .busRdata(rd[0]), .pinIn(pinIn), .pinOut(po[0]), .pinOe(poe[0]),
    .irq(irqs[0]));
  pio_edge_top #(.PIN_COUNT(NP), .TRIG(TRIG_FALL)) dutFall (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busWordAddr(busWordAddr),
    .busWdata(busWdata), .busRdata(rd[1]), .pinIn(pinIn), .pinOut(po[1]), .pinOe(poe[1]),
    .irq(irqs[1]));
  pio_edge_top #(.PIN_COUNT(NP), .TRIG(TRIG_BOTH)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busWordAddr(busWordAddr),
    .busWdata(busWdata), .busRdata(rd[2]), .pinIn(pinIn), .pinOut(po[2]), .pinOe(poe[2]),
    .irq(irqs[2]));
  pio_edge_top #(.PIN_COUNT(NP), .TRIG(TRIG_LEVEL)) dutLvl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busWordAddr(busWordAddr),
    .busWdata(busWdata), .busRdata(rd[3]), .pinIn(pinIn), .pinOut(po[3]), .pinOe(poe[3]),
    .irq(irqs[3]));

  // ---------------- behavioural reference ----------------
  logic [NP-1:0] mOut, mDir, mMask;
  logic [NP-1:0] mCap [4];
  logic          mIrq [4];
  logic [NP-1:0] hist [$];   // hist[0] newest pin sample

  function automatic logic [NP-1:0] seenLevel();
    return (hist.size() > 1) ? hist[1] : '0;
  endfunction

  function automatic logic [NP-1:0] modelData();
    return (mOut & mDir) | (seenLevel() & ~mDir);
  endfunction

  function automatic logic [31:0] modelRead(input int k, input logic [1:0] a);
    case (a)
      2'd0:    return 32'(modelData());
      2'd1:    return 32'(mDir);
      2'd2:    return 32'(mMask);
      default: return 32'(mCap[k]);
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mOut = '0; mDir = '0; mMask = '0;
      for (int k = 0; k < 4; k++) begin mCap[k] = '0; mIrq[k] = 1'b0; end
      hist.delete();
      repeat (3) hist.push_back('0);
    end else begin
      logic [NP-1:0] cur, prv, ev, clr, dv;
      cur = hist[1];
      prv = hist[2];
      dv  = modelData();
      clr = (busSel && busWr && busWordAddr == 2'd3) ? busWdata[NP-1:0] : '0;
      for (int k = 0; k < 4; k++) begin
        mIrq[k] = (k == 3) ? |(dv & mMask) : |(mCap[k] & mMask);
        case (k)
          0:       ev = cur & ~prv;
          1:       ev = ~cur & prv;
          2:       ev = cur ^ prv;
          default: ev = '0;
        endcase
        mCap[k] = (k == 3) ? '0 : ((mCap[k] & ~clr) | ev);
      end
      if (busSel && busWr) begin
        case (busWordAddr)
          2'd0: mOut  = busWdata[NP-1:0];
          2'd1: mDir  = busWdata[NP-1:0];
          2'd2: mMask = busWdata[NP-1:0];
          default: ;
        endcase
      end
      hist.push_front(pinIn);
      void'(hist.pop_back());
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    if (rstN && hist.size() == 3) begin
      for (int k = 0; k < 4; k++) begin
        check(irqs[k] == mIrq[k], (k == 3) ? "R9 irq level" : "R8 irq edge",
              32'(irqs[k]), 32'(mIrq[k]));
        check(po[k] == mOut && poe[k] == mDir, "R2 pinOut/pinOe",
              {po[k], 4'h0, poe[k]}, {mOut, 4'h0, mDir});
        if (busSel && !busWr)
          check(rd[k] == modelRead(k, busWordAddr), "R1/R3 readback",
                rd[k], modelRead(k, busWordAddr));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busWordAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic expectRead(input logic [1:0] a, input int k, input logic [31:0] e,
                            input string tag);
    busSel = 1'b1; busWr = 1'b0; busWordAddr = a;
    @(negedge clk);
    check(rd[k] == e, tag, rd[k], e);
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic expectIrq(input int k, input logic e, input string tag);
    @(negedge clk);
    check(irqs[k] == e, tag, 32'(irqs[k]), 32'(e));
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nChecks++; nBad++;
    $display("FAIL watchdog expired act=running exp=finished");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'hACE1_1234;
    repeat (4) @(posedge clk);
    #1;
    // R4 reset state seen during reset
    check(poe[2] == '0 && po[2] == '0 && irqs == 4'h0, "R4 outputs in reset", 
          {po[2], 4'h0, poe[2]}, 32'h0);
    rstN = 1'b1;
    idle(1);
    for (int a = 0; a < 4; a++) expectRead(2'(a), 2, 32'h0, "R4 register reset value");

    // R5 upper bits dropped, R2 enables follow direction
    busWrite(2'd1, 32'hFFFF_F0F0);
    expectRead(2'd1, 2, 32'h0000_00F0, "R5 direction upper bits");
    check(poe[2] == 12'h0F0, "R2 pinOe after write", 32'(poe[2]), 32'h0F0);
    busWrite(2'd0, 32'h0000_0ABC);
    check(po[2] == 12'hABC, "R2 pinOut after write", 32'(po[2]), 32'hABC);
    expectRead(2'd0, 2, 32'h0B0, "R3 data mixes outputs and inputs");

    // rising pins 0..3
    pinIn = 12'h00F;
    idle(1);
    expectRead(2'd0, 2, 32'h0B0, "R3 level not yet through synchronizer");
    idle(2);
    expectRead(2'd0, 2, 32'h0BF, "R3 synchronized inputs");
    expectRead(2'd3, 0, 32'h00F, "R6 rise capture");
    expectRead(2'd3, 1, 32'h000, "R6 fall ignores rising");
    expectRead(2'd3, 2, 32'h00F, "R6 both capture");
    expectRead(2'd3, 3, 32'h000, "R6 level mode capture reads zero");
    expectIrq(2, 1'b0, "R10 mask zero keeps irq low");
    expectIrq(3, 1'b0, "R10 mask zero keeps level irq low");

    busWrite(2'd2, 32'h003);
    idle(1);
    expectIrq(0, 1'b1, "R8 rise irq");
    expectIrq(1, 1'b0, "R8 fall irq stays low");
    expectIrq(3, 1'b1, "R9 level irq from pin data");

    // R7 clear behaviour
    busWrite(2'd3, 32'h001);
    expectRead(2'd3, 0, 32'h00E, "R7 write one clears");
    busWrite(2'd3, 32'h000);
    expectRead(2'd3, 0, 32'h00E, "R7 write zero keeps");

    pinIn = 12'h000;
    idle(4);
    expectRead(2'd3, 1, 32'h00F, "R6 fall capture");
    expectRead(2'd3, 2, 32'h00F, "R6 both capture falling");
    expectRead(2'd3, 0, 32'h00E, "R6 rise ignores falling");

    // R7 set wins over a simultaneous clear
    busWrite(2'd3, 32'hFFF);
    expectRead(2'd3, 2, 32'h000, "R7 clear all");
    pinIn = 12'h100;
    @(posedge clk); #1;
    @(posedge clk); #1;
    busWrite(2'd3, 32'h100);
    expectRead(2'd3, 0, 32'h100, "R7 set beats clear rise");
    expectRead(2'd3, 2, 32'h100, "R7 set beats clear both");

    // R9 level behaviour with mask on pin 8
    busWrite(2'd2, 32'h000);
    idle(1);
    expectIrq(3, 1'b0, "R10 level masked");
    busWrite(2'd2, 32'h100);
    idle(1);
    expectIrq(3, 1'b1, "R9 level irq asserted");
    pinIn = 12'h000;
    idle(3);
    expectIrq(3, 1'b0, "R9 level irq follows pin");

    // mixed traffic, reference compares every clock
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'h5) pinIn = lfsr[27:16];
      else if (lfsr[3:0] == 4'hA) pinIn[lfsr[7:4] % NP] = ~pinIn[lfsr[7:4] % NP];
      if (lfsr[10:8] == 3'd0) begin
        busWrite(lfsr[13:12], {lfsr[31:20], lfsr[19:0]});
      end else if (lfsr[10:8] == 3'd1) begin
        busSel = 1'b1; busWr = 1'b0; busWordAddr = lfsr[15:14];
        idle(1);
        busSel = 1'b0;
      end else begin
        idle(1);
      end
    end
    idle(2);
    finishRun();
  end

endmodule